// File: doc/BRIEF.md
# Synchronized DMA Transfer Channel

A single-channel DMA engine that copies words across a shared synchronous bus, where each end of the copy may sit in memory space or in I/O space. For every accepted request the channel raises a bus request and waits for a grant. It then reads one word from the source into a holding register, writes that word to the destination, and returns the bus. The source and destination addresses can each advance by one word per transfer or stay fixed. A down-counter sets how many transfers the channel performs before it disarms itself, sets a completion flag and pulses an interrupt.

Firmware chooses whether the request line is paced by the device that supplies the data or by the device that takes it. When the supplier paces it, the channel looks at the request again the moment a write finishes and can start the next read while it still owns the bus. When the receiver paces it, the channel first gives the bus back and waits a fixed number of idle cycles, so a slow device has time to withdraw its request. An internal periodic timer can replace the external request line. In that mode every transfer writes to a fixed unused memory address, which turns the channel into a refresh reader that touches memory at a steady rate.

Top module: `dma_sync_channel`

## Requirements
- R1: While reset is held and on the first cycle after it, bus_req, bus_valid, irq, done and busy are all low.
- R2: A bus cycle (bus_valid high) only occurs while bus_req is high, and a bus cycle begins only after a cycle in which bus_gnt was high. bus_req is lowered once the final transfer's write completes.
- R3: Configuration writes use index 0 for the source address, 1 for the destination address, 2 for the transfer count, 3 for control and 4 for the timer period. Each transfer reads the source address and then writes the word it read to the destination address. Control bit 1 puts the source in I/O space and control bit 2 puts the destination in I/O space, shown as bus_io=1 during the cycle. Control bit 0 enables the channel.
- R4: After each transfer the source address increases by one if control bit 3 is set, and the destination address increases by one if control bit 4 is set. A cleared bit keeps that address fixed.
- R5: Each transfer decreases the count by one. After the programmed number of transfers, exactly that many writes have taken place, done is high, the enable bit is cleared and irq has been high for exactly one cycle.
- R6: Once done is set, the request input starts no bus activity. A control write with bit 0 set clears done and rearms the channel.
- R7: With control bit 5 clear (source paced), a request that is still present when a write completes starts the next read without lowering bus_req. A request held through the last transfer causes no extra transfer.
- R8: With control bit 5 set (destination paced), bus_req is lowered after every write. It stays low for GAP_CYCLES+1 clock cycles (3 by default) before a held request raises it again.
- R9: With control bit 6 set, an internal timer with the period from index 4 replaces the external request, which is then ignored. Reads come from memory space, and every write goes to memory address DUMMY_ADDR (all ones by default), one write per period.
- R10: If bus_gnt falls while a bus cycle is in progress, that cycle still runs to completion. No new bus cycle starts until bus_gnt is high again.
- R11: Once bus_valid is high, bus_valid, bus_addr, bus_we and bus_io hold steady until a cycle in which bus_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | DATA_W | Configuration write value |
| ext_req | input | 1 | Asynchronous external transfer request (level) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | DATA_W | Write data (holding register) |
| bus_rdata | input | DATA_W | Read data, taken when bus_ready is high |
| bus_ready | input | 1 | Ends the current bus cycle |
| irq | output | 1 | One-cycle completion pulse |
| done | output | 1 | Transfer count exhausted |
| busy | output | 1 | Channel is not idle |

## Verification
Two events can land in the same clock edge. The write that finishes the last transfer can meet a request that is still high, and in source-paced mode that same edge is also the point where the request is sampled again. The bench keeps the request high from start to finish in every one of the 32 combinations of space, increment and pacing mode, with bus wait states varied across runs. A pass requires exactly the programmed number of writes, a single irq pulse and no bus request for a further thirty cycles. A separate case drops the grant in the middle of a read that has wait states. It requires the read to finish, no write cycle to appear while the grant is low, and the correct word to land once the grant returns.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_GAP   = 2'd3
  } chan_state_e;

  // control register, bit 0 is enable (LSB)
  typedef struct packed {
    logic timer_mode;  // bit 6
    logic dst_sync;    // bit 5
    logic dst_inc;     // bit 4
    logic src_inc;     // bit 3
    logic dst_io;      // bit 2
    logic src_io;      // bit 1
    logic enable;      // bit 0
  } chan_ctrl_t;

  localparam int CTRL_W = 7;

  localparam logic [2:0] REG_SRC    = 3'd0;
  localparam logic [2:0] REG_DST    = 3'd1;
  localparam logic [2:0] REG_CNT    = 3'd2;
  localparam logic [2:0] REG_CTRL   = 3'd3;
  localparam logic [2:0] REG_PERIOD = 3'd4;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dma_tick_gen.sv
module dma_tick_gen #(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [TMR_W-1:0] period_i,
  output logic             tick_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (period_i <= TMR_W'(1)) || (cnt_q >= period_i - TMR_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + TMR_W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int TMR_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              step_i,
  input  logic              finish_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output chan_ctrl_t        ctrl_o,
  output logic [TMR_W-1:0]  period_o,
  output logic              done_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_o    <= '0;
      dst_o    <= '0;
      cnt_o    <= '0;
      ctrl_o   <= '0;
      period_o <= '0;
      done_o   <= 1'b0;
    end else begin
      if (step_i) begin
        if (ctrl_o.src_inc) src_o <= src_o + ADDR_W'(1);
        if (ctrl_o.dst_inc && !ctrl_o.timer_mode) dst_o <= dst_o + ADDR_W'(1);
        cnt_o <= cnt_o - CNT_W'(1);
      end
      if (finish_i) begin
        ctrl_o.enable <= 1'b0;
        done_o        <= 1'b1;
      end
      if (cfg_we) begin
        unique case (cfg_addr)
          REG_SRC:    src_o    <= cfg_wdata[ADDR_W-1:0];
          REG_DST:    dst_o    <= cfg_wdata[ADDR_W-1:0];
          REG_CNT:    cnt_o    <= cfg_wdata[CNT_W-1:0];
          REG_CTRL: begin
            ctrl_o <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            if (cfg_wdata[0]) done_o <= 1'b0;
          end
          REG_PERIOD: period_o <= cfg_wdata[TMR_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_sync_channel.sv
module dma_sync_channel
  import dma_chan_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 16,
  parameter int                CNT_W       = 8,
  parameter int                TMR_W       = 12,
  parameter int                GAP_CYCLES  = 2,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DUMMY_ADDR  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ext_req,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_we,
  output logic              bus_io,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              irq,
  output logic              done,
  output logic              busy
);
  localparam int GAP_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);

  chan_state_e       state_q;
  logic              cyc_q, req_q, irq_q, pend_q;
  logic [DATA_W-1:0] hold_q;
  logic [GAP_W-1:0]  gap_q;

  logic [ADDR_W-1:0] src_a, dst_a, dst_eff;
  logic [CNT_W-1:0]  cnt;
  chan_ctrl_t        ctrl;
  logic [TMR_W-1:0]  period;
  logic              ext_s, tick, trig, hs, last, step, finish;
  logic              start_idle, chain, accept, src_io_eff, dst_io_eff;

  dma_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TMR_W(TMR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .step_i(step), .finish_i(finish),
    .src_o(src_a), .dst_o(dst_a), .cnt_o(cnt), .ctrl_o(ctrl),
    .period_o(period), .done_o(done)
  );

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(ext_req), .sync_o(ext_s)
  );

  dma_tick_gen #(.TMR_W(TMR_W)) u_tick (
    .clk(clk), .rst(rst), .run_i(ctrl.enable && ctrl.timer_mode),
    .period_i(period), .tick_o(tick)
  );

  // request source, effective endpoints
  assign trig       = ctrl.timer_mode ? pend_q : ext_s;
  assign dst_eff    = ctrl.timer_mode ? DUMMY_ADDR : dst_a;
  assign dst_io_eff = ctrl.timer_mode ? 1'b0 : ctrl.dst_io;
  assign src_io_eff = ctrl.timer_mode ? 1'b0 : ctrl.src_io;

  // handshake decode
  assign hs         = cyc_q && bus_ready;
  assign last       = (cnt == CNT_W'(1));
  assign step       = (state_q == ST_WRITE) && hs;
  assign finish     = step && last;
  assign start_idle = (state_q == ST_IDLE) && ctrl.enable && (cnt != '0) && trig;
  assign chain      = step && !last && !ctrl.dst_sync && trig;
  assign accept     = start_idle || chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cyc_q   <= 1'b0;
      req_q   <= 1'b0;
      irq_q   <= 1'b0;
      hold_q  <= '0;
      gap_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_idle) begin
            req_q   <= 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (hs) begin
            cyc_q   <= 1'b0;
            hold_q  <= bus_rdata;
            state_q <= ST_WRITE;
          end else if (!cyc_q && bus_gnt) begin
            cyc_q <= 1'b1;
          end
        end
        ST_WRITE: begin
          if (hs) begin
            cyc_q <= 1'b0;
            if (last) begin
              req_q   <= 1'b0;
              irq_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else if (!ctrl.dst_sync) begin
              if (trig) begin
                state_q <= ST_READ;
              end else begin
                req_q   <= 1'b0;
                state_q <= ST_IDLE;
              end
            end else begin
              req_q   <= 1'b0;
              gap_q   <= '0;
              state_q <= ST_GAP;
            end
          end else if (!cyc_q && bus_gnt) begin
            cyc_q <= 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_CYCLES - 1)) state_q <= ST_IDLE;
          else gap_q <= gap_q + GAP_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // timer request latch: a new tick wins over a same-cycle accept
  always_ff @(posedge clk) begin
    if (rst || !(ctrl.enable && ctrl.timer_mode)) pend_q <= 1'b0;
    else pend_q <= tick || (pend_q && !accept);
  end

  assign bus_req   = req_q;
  assign bus_valid = cyc_q;
  assign bus_we    = (state_q == ST_WRITE);
  assign bus_io    = (state_q == ST_WRITE) ? dst_io_eff : src_io_eff;
  assign bus_addr  = (state_q == ST_WRITE) ? dst_eff : src_a;
  assign bus_wdata = hold_q;
  assign irq       = irq_q;
  assign busy      = (state_q != ST_IDLE);

  AST_VALID_UNDER_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> bus_req); // R2
  AST_START_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(bus_gnt)); // R10
  AST_CYCLE_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_io)); // R11
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req); // R6
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) && ctrl.dst_sync && !done |=> !bus_req); // R8
  AST_REFRESH_TARGET: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_we && ctrl.timer_mode |-> (bus_addr == DUMMY_ADDR) && !bus_io); // R9
endmodule

// File: tb/dma_sync_channel_test.sv
module dma_sync_channel_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int GAP = 2;
  localparam logic [AW-1:0] DUMMY = 8'hFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          ext_req = 1'b0;
  logic          bus_req, bus_valid, bus_we, bus_io, irq, done, busy;
  logic          bus_gnt = 1'b0;
  logic          bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  dma_sync_channel uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ext_req(ext_req), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq), .done(done), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] iom [256];
  int  wait_states = 0, wcnt = 0;
  bit  gnt_allow = 1;
  int  irq_cnt, wr_cnt, rd_cnt, req_fall, req_rise, min_gap, last_wr_cyc;
  bit  prev_req = 0, saw_wr_valid = 0;
  int  wr_cyc [16];
  logic [AW-1:0] wr_addr [16];
  logic [DW-1:0] wr_data [16];
  bit  wr_io [16];

  always @(posedge clk) cyc++;

  // monitors and bus responder, all at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 0; bus_gnt = 0; wcnt = 0; prev_req = 0;
    end else begin
      if (irq) irq_cnt++;
      if (bus_valid && bus_we) saw_wr_valid = 1;
      if (prev_req && !bus_req) req_fall++;
      if (!prev_req && bus_req) begin
        req_rise++;
        if (wr_cnt > 0 && (cyc - last_wr_cyc) < min_gap) min_gap = cyc - last_wr_cyc;
      end
      prev_req = bus_req;
      if (bus_ready) bus_ready = 0;
      else if (bus_valid) begin
        if (wcnt >= wait_states) begin
          bus_ready = 1; wcnt = 0;
          if (bus_we) begin
            if (bus_io) iom[bus_addr] = bus_wdata; else mem[bus_addr] = bus_wdata;
            if (wr_cnt < 16) begin
              wr_cyc[wr_cnt] = cyc; wr_addr[wr_cnt] = bus_addr;
              wr_data[wr_cnt] = bus_wdata; wr_io[wr_cnt] = bus_io;
            end
            wr_cnt++; last_wr_cyc = cyc;
          end else begin
            bus_rdata = bus_io ? iom[bus_addr] : mem[bus_addr];
            rd_cnt++;
          end
        end else wcnt++;
      end
      bus_gnt = bus_req && gnt_allow;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] a, input int v);
    @(negedge clk); #1;
    cfg_we = 1; cfg_addr = a; cfg_wdata = DW'(v);
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic clear_logs();
    irq_cnt = 0; wr_cnt = 0; rd_cnt = 0; req_fall = 0; req_rise = 0;
    min_gap = 1000; saw_wr_valid = 0;
  endtask

  task automatic fill_mem();
    for (int a = 0; a < 256; a++) begin
      mem[a] = DW'(16'h1000 + a * 3);
      iom[a] = DW'(16'h8000 ^ (a * 7));
    end
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] orig(input bit io, input int a);
    return io ? DW'(16'h8000 ^ (a * 7)) : DW'(16'h1000 + a * 3);
  endfunction

  task automatic sweep_run(input bit sio, input bit dio, input bit sinc, input bit dinc,
                           input bit dsync, input int ws);
    int n = 3, s0 = 8'h20, d0 = 8'h60, base;
    logic [DW-1:0] got, exp;
    fill_mem();
    wait_states = ws;
    clear_logs();
    wr_cfg(3'd0, s0);
    wr_cfg(3'd1, d0);
    wr_cfg(3'd2, n);
    wr_cfg(3'd3, 1 | (int'(sio) << 1) | (int'(dio) << 2) | (int'(sinc) << 3)
                 | (int'(dinc) << 4) | (int'(dsync) << 5));
    ext_req = 1;
    wait_done(3000);
    chk(done == 1, "R5 done", int'(done), 1);
    chk(irq_cnt == 1, "R5 irq pulses", irq_cnt, 1);
    chk(wr_cnt == n, "R7 write count with held request", wr_cnt, n);
    for (int k = 0; k < n; k++) begin
      chk(wr_addr[k] == AW'(d0 + (dinc ? k : 0)), "R4 dest address", int'(wr_addr[k]), d0 + (dinc ? k : 0));
      chk(wr_io[k] == dio, "R3 dest space", int'(wr_io[k]), int'(dio));
      exp = orig(sio, s0 + (sinc ? k : 0));
      chk(wr_data[k] == exp, "R3 R4 moved word", int'(wr_data[k]), int'(exp));
    end
    got = dio ? iom[dinc ? d0 + n - 1 : d0] : mem[dinc ? d0 + n - 1 : d0];
    exp = orig(sio, s0 + (sinc ? n - 1 : 0));
    chk(got == exp, "R3 final dest content", int'(got), int'(exp));
    if (!dinc) begin
      got = dio ? iom[d0 + 1] : mem[d0 + 1];
      chk(got == orig(dio, d0 + 1), "R4 fixed dest neighbour untouched", int'(got), int'(orig(dio, d0 + 1)));
    end
    if (!dsync) chk(req_fall == 1, "R7 bus kept across transfers", req_fall, 1);
    else begin
      chk(req_fall == n, "R8 bus released per transfer", req_fall, n);
      chk(min_gap == GAP + 2, "R8 idle gap", min_gap, GAP + 2);
    end
    // R6: held request after completion starts nothing
    base = req_rise;
    repeat (30) @(negedge clk);
    chk(req_rise == base && !bus_req, "R6 ignored after done", req_rise - base, 0);
    chk(wr_cnt == n, "R6 no extra write", wr_cnt, n);
    ext_req = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fill_mem();
    clear_logs();
    repeat (4) @(negedge clk);
    chk(!bus_req && !bus_valid && !irq && !done && !busy, "R1 reset outputs", int'({bus_req, bus_valid, irq, done, busy}), 0);
    #1 rst = 0;
    @(negedge clk);
    chk(!bus_req && !bus_valid && !irq && !done && !busy, "R1 after reset", int'({bus_req, bus_valid, irq, done, busy}), 0);

    // near-exhaustive sweep: spaces x increments x pacing, varying wait states
    for (int v = 0; v < 32; v++)
      sweep_run(v[0], v[1], v[2], v[3], v[4], v % 3);

    // R6 rearm after done
    clear_logs();
    wait_states = 0;
    wr_cfg(3'd0, 8'h05);
    wr_cfg(3'd1, 8'h70);
    wr_cfg(3'd2, 1);
    ext_req = 1;
    wr_cfg(3'd3, 1);
    chk(done == 0, "R6 rearm clears done", int'(done), 0);
    wait_done(500);
    chk(wr_cnt == 1 && mem[8'h70] == orig(0, 5), "R6 rearmed transfer", wr_cnt, 1);
    ext_req = 0;
    repeat (4) @(negedge clk);

    // R10 grant removed mid read
    fill_mem();
    clear_logs();
    wait_states = 3;
    wr_cfg(3'd0, 8'h33);
    wr_cfg(3'd1, 8'h44);
    wr_cfg(3'd2, 1);
    wr_cfg(3'd3, 1);
    ext_req = 1;
    for (int i = 0; i < 200 && !bus_valid; i++) @(negedge clk);
    #1 gnt_allow = 0;
    repeat (14) @(negedge clk);
    chk(rd_cnt == 1, "R10 read finishes without grant", rd_cnt, 1);
    chk(!saw_wr_valid && wr_cnt == 0, "R10 no write while ungranted", wr_cnt, 0);
    #1 gnt_allow = 1;
    wait_done(500);
    chk(wr_cnt == 1 && mem[8'h44] == orig(0, 8'h33), "R10 completes after regrant", int'(mem[8'h44]), int'(orig(0, 8'h33)));
    ext_req = 0;
    repeat (4) @(negedge clk);

    // R9 timer-driven refresh, external request held but ignored
    fill_mem();
    clear_logs();
    wait_states = 0;
    wr_cfg(3'd0, 8'h20);
    wr_cfg(3'd1, 8'h10);
    wr_cfg(3'd2, 3);
    wr_cfg(3'd4, 25);
    ext_req = 1;
    wr_cfg(3'd3, 1 | (1 << 3) | (1 << 6));
    wait_done(1000);
    chk(wr_cnt == 3, "R9 refresh writes", wr_cnt, 3);
    for (int k = 0; k < 3; k++) begin
      chk(wr_addr[k] == DUMMY && !wr_io[k], "R9 dummy target", int'(wr_addr[k]), int'(DUMMY));
      chk(wr_data[k] == orig(0, 8'h20 + k), "R9 memory read data", int'(wr_data[k]), int'(orig(0, 8'h20 + k)));
    end
    for (int k = 0; k < 2; k++)
      chk(wr_cyc[k + 1] - wr_cyc[k] == 25, "R9 period", wr_cyc[k + 1] - wr_cyc[k], 25);
    chk(mem[8'h10] == orig(0, 8'h10), "R9 dest register unused", int'(mem[8'h10]), int'(orig(0, 8'h10)));
    ext_req = 0;

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule